// File: doc/BRIEF.md
# UART Receive Idle Time-out Detector

This block sits next to a UART receiver and detects the end of a variable-length frame. It watches for an idle gap on the receive line that follows received traffic. A 16-bit down-counter is loaded with a programmed time-out value each time a character arrives. The counter steps down once per bit period, driven by a bit-period tick from the baud logic. When it reaches zero, a sticky time-out status bit is set, and an interrupt request follows that bit when the interrupt is enabled.

Software acknowledges the time-out with a start-time-out command. This command clears the status and freezes the countdown until the next character arrives. An idle line therefore raises the status once per gap and never again until traffic resumes. A programmed value of zero turns detection off entirely. The block only counts. The serial receiver, the baud generator and the register file that produce its inputs are outside it.

Top module: `uart_idle_timeout`

## Requirements
- R1: After reset, timeout_o and irq_o are 0. Bit ticks that arrive before the first character_rx_i pulse never set timeout_o.
- R2: While to_value_i is 0, timeout_o is 0 from the next clock edge onward. A character received with a value of 0 never leads to a time-out.
- R3: A char_rx_i pulse with nonzero value V loads the counter with V. timeout_o is still 0 after V-1 bit ticks and is 1 right after the clock edge that samples the V-th tick. With V = 1, the first tick sets it.
- R4: The countdown advances only on clock cycles with bit_tick_i high. Clock cycles without a tick do not move it.
- R5: A char_rx_i pulse during a countdown reloads the counter with the value, so the full V ticks are needed again after it.
- R6: timeout_o is sticky. Once it is set, it stays 1 through further ticks until start_to_i or a zero value clears it, and it is set only once per idle gap.
- R7: A start_to_i pulse clears timeout_o and stops the countdown, both after a time-out and in the middle of a countdown. Ticks are then ignored until the next char_rx_i pulse reloads the counter and restarts counting.
- R8: If start_to_i and char_rx_i arrive in the same cycle, timeout_o is cleared and the counter is reloaded and running. A time-out then follows after V ticks.
- R9: A change of to_value_i during a countdown does not affect it. The new value is used from the next char_rx_i reload on.
- R10: If char_rx_i and bit_tick_i arrive in the same cycle, the reload wins. That tick is not counted, and V further ticks are needed.
- R11: irq_o equals timeout_o AND irq_en_i.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_i | input | 1 | System clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| bit_tick_i | input | 1 | One-cycle pulse per receive bit period |
| char_rx_i | input | 1 | One-cycle pulse per received character |
| to_value_i | input | 16 | Programmed time-out in bit periods, 0 = disabled |
| start_to_i | input | 1 | Start-time-out command strobe: clears status, freezes counter |
| irq_en_i | input | 1 | Time-out interrupt enable |
| timeout_o | output | 1 | Sticky time-out status |
| irq_o | output | 1 | Time-out interrupt request |

## Verification
The bench counts ticks exactly to the expiry edge, with V-1 and V ticks and with V = 1, so that an off-by-one countdown shows at once. It sends ticks before any character and after a start command. A design that free-runs from reset or ignores the freeze would then raise repeated time-outs on an idle line. It puts a character and a tick in the same cycle, and a command and a character in the same cycle; a wrong priority gives a time-out one tick early or a counter left frozen. It also changes the value mid-count and programs zero, where a design that samples the value live would expire early or report a disabled time-out.

// File: rtl/uart_ito_pkg.sv
package uart_ito_pkg;
  localparam int unsigned CNT_W = 16;
  typedef logic [CNT_W-1:0] cnt_t;
endpackage

// File: rtl/ito_ctrl.sv
module ito_ctrl (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic bit_tick_i,
  input  logic char_rx_i,
  input  logic start_to_i,
  input  logic cfg_nz_i,
  input  logic expire_i,
  output logic load_o,
  output logic dec_o
);
  logic run_q;

  // reload on every character; a zero value leaves the counter stopped
  assign load_o = char_rx_i;
  assign dec_o  = run_q && bit_tick_i && !char_rx_i && !start_to_i;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)          run_q <= 1'b0;
    else if (char_rx_i)   run_q <= cfg_nz_i;
    else if (start_to_i)  run_q <= 1'b0;
    else if (expire_i)    run_q <= 1'b0;
  end

  // R7
  frozen_stays_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!run_q && !char_rx_i) |=> !run_q);
endmodule

// File: rtl/ito_counter.sv
module ito_counter
  import uart_ito_pkg::*;
(
  input  logic clk_i,
  input  logic rst_ni,
  input  logic load_i,
  input  logic dec_i,
  input  cnt_t val_i,
  output logic expire_o
);
  cnt_t cnt_q;

  assign expire_o = dec_i && (cnt_q == cnt_t'(1));

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)                        cnt_q <= '0;
    else if (load_i)                    cnt_q <= val_i;
    else if (dec_i && cnt_q != '0)      cnt_q <= cnt_q - cnt_t'(1);
  end

  // R10
  reload_value_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    load_i |=> (cnt_q == $past(val_i)));
  // R5
  no_count_up_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!load_i) |=> (cnt_q <= $past(cnt_q)));
endmodule

// File: rtl/ito_status.sv
module ito_status (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic cfg_nz_i,
  input  logic start_to_i,
  input  logic expire_i,
  input  logic irq_en_i,
  output logic status_o,
  output logic irq_o
);
  logic status_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)          status_q <= 1'b0;
    else if (!cfg_nz_i)   status_q <= 1'b0;
    else if (start_to_i)  status_q <= 1'b0;
    else if (expire_i)    status_q <= 1'b1;
  end

  assign status_o = status_q;
  assign irq_o    = status_q && irq_en_i;

  // R6
  sticky_status_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (status_q && !start_to_i && cfg_nz_i) |=> status_q);
endmodule

// File: rtl/uart_idle_timeout.sv
module uart_idle_timeout
  import uart_ito_pkg::*;
(
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             bit_tick_i,
  input  logic             char_rx_i,
  input  logic [CNT_W-1:0] to_value_i,
  input  logic             start_to_i,
  input  logic             irq_en_i,
  output logic             timeout_o,
  output logic             irq_o
);
  logic cfg_nz, load, dec, expire;

  assign cfg_nz = (to_value_i != '0);

  ito_ctrl u_ctrl (
    .clk_i, .rst_ni, .bit_tick_i, .char_rx_i, .start_to_i,
    .cfg_nz_i(cfg_nz), .expire_i(expire), .load_o(load), .dec_o(dec)
  );

  ito_counter u_cnt (
    .clk_i, .rst_ni, .load_i(load), .dec_i(dec), .val_i(to_value_i),
    .expire_o(expire)
  );

  ito_status u_stat (
    .clk_i, .rst_ni, .cfg_nz_i(cfg_nz), .start_to_i, .expire_i(expire),
    .irq_en_i, .status_o(timeout_o), .irq_o
  );

  // R3
  rise_on_tick_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(timeout_o) |-> $past(bit_tick_i));
  // R2
  zero_disables_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (to_value_i == '0) |=> !timeout_o);
  // R7
  start_clears_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    start_to_i |=> !timeout_o);
  // R11
  irq_gated_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    irq_o |-> (timeout_o && irq_en_i));
endmodule

// File: tb/uart_idle_timeout_bench.sv
module uart_idle_timeout_bench;
  timeunit 1ns;
  timeprecision 100ps;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic tick = 1'b0, chr = 1'b0, stt = 1'b0, ien = 1'b0;
  logic [15:0] val = 16'd0;
  logic to_w, irq_w;
  int checks = 0, errors = 0;
  bit done = 1'b0;

  always #2.5 clk = ~clk;

  uart_idle_timeout u_uart_idle_timeout (
    .clk_i(clk), .rst_ni(rst_n), .bit_tick_i(tick), .char_rx_i(chr),
    .to_value_i(val), .start_to_i(stt), .irq_en_i(ien),
    .timeout_o(to_w), .irq_o(irq_w)
  );

  task automatic chk(input logic act, input logic exp, input string req);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual %b expected %b", req, act, exp);
    end
  endtask

  // one clock edge with the given strobes; returns at the following negedge
  task automatic step(input logic t, input logic c, input logic s);
    tick = t; chr = c; stt = s;
    @(negedge clk);
    tick = 1'b0; chr = 1'b0; stt = 1'b0;
  endtask

  task automatic ticks(input int n);
    for (int i = 0; i < n; i++) step(1'b1, 1'b0, 1'b0);
  endtask

  task automatic idle(input int n);
    for (int i = 0; i < n; i++) step(1'b0, 1'b0, 1'b0);
  endtask

  task automatic t_reset;
    chk(to_w, 1'b0, "R1 timeout after reset");
    chk(irq_w, 1'b0, "R1 irq after reset");
    val = 16'd3;
    ticks(20);
    chk(to_w, 1'b0, "R1 no timeout before first char");
  endtask

  task automatic t_basic;
    val = 16'd5; ien = 1'b1;
    step(1'b0, 1'b1, 1'b0);
    ticks(4);
    chk(to_w, 1'b0, "R3 after V-1 ticks");
    ticks(1);
    chk(to_w, 1'b1, "R3 after V ticks");
    chk(irq_w, 1'b1, "R11 irq enabled");
    ien = 1'b0; #1;
    chk(irq_w, 1'b0, "R11 irq masked");
    ticks(30);
    chk(to_w, 1'b1, "R6 status sticky");
    step(1'b0, 1'b0, 1'b1);
    chk(to_w, 1'b0, "R7 start clears");
    ticks(20);
    chk(to_w, 1'b0, "R7 frozen after start");
  endtask

  task automatic t_no_tick;
    step(1'b0, 1'b1, 1'b0);
    idle(40);
    chk(to_w, 1'b0, "R4 clocks without ticks");
    ticks(4);
    chk(to_w, 1'b0, "R4 V-1 ticks after idle");
    ticks(1);
    chk(to_w, 1'b1, "R4 V ticks after idle");
    step(1'b0, 1'b0, 1'b1);
  endtask

  task automatic t_reload;
    step(1'b0, 1'b1, 1'b0);
    ticks(3);
    step(1'b0, 1'b1, 1'b0);
    ticks(4);
    chk(to_w, 1'b0, "R5 reload restarts count");
    ticks(1);
    chk(to_w, 1'b1, "R5 expire after full V");
    step(1'b0, 1'b0, 1'b1);
  endtask

  task automatic t_value_change;
    val = 16'd5;
    step(1'b0, 1'b1, 1'b0);
    val = 16'd2;
    ticks(4);
    chk(to_w, 1'b0, "R9 new value not used mid count");
    ticks(1);
    chk(to_w, 1'b1, "R9 old value expires");
    step(1'b0, 1'b0, 1'b1);
    step(1'b0, 1'b1, 1'b0);
    ticks(1);
    chk(to_w, 1'b0, "R9 new value 1 tick");
    ticks(1);
    chk(to_w, 1'b1, "R9 new value at reload");
    step(1'b0, 1'b0, 1'b1);
  endtask

  task automatic t_char_tick;
    val = 16'd3;
    step(1'b0, 1'b1, 1'b0);
    ticks(1);
    step(1'b1, 1'b1, 1'b0);
    ticks(2);
    chk(to_w, 1'b0, "R10 tick with char not counted");
    ticks(1);
    chk(to_w, 1'b1, "R10 expire after V more");
  endtask

  task automatic t_start_char;
    step(1'b0, 1'b1, 1'b1);
    chk(to_w, 1'b0, "R8 start with char clears");
    ticks(2);
    chk(to_w, 1'b0, "R8 counting V-1");
    ticks(1);
    chk(to_w, 1'b1, "R8 running after start with char");
    step(1'b0, 1'b0, 1'b1);
  endtask

  task automatic t_freeze_mid;
    val = 16'd3;
    step(1'b0, 1'b1, 1'b0);
    ticks(1);
    step(1'b0, 1'b0, 1'b1);
    ticks(15);
    chk(to_w, 1'b0, "R7 freeze mid count");
    step(1'b0, 1'b1, 1'b0);
    ticks(2);
    chk(to_w, 1'b0, "R7 resumed V-1");
    ticks(1);
    chk(to_w, 1'b1, "R7 resumes after char");
  endtask

  task automatic t_zero;
    val = 16'd0;
    step(1'b0, 1'b0, 1'b0);
    chk(to_w, 1'b0, "R2 zero value clears status");
    step(1'b0, 1'b1, 1'b0);
    ticks(20);
    chk(to_w, 1'b0, "R2 char with zero value");
    val = 16'd4;
    ticks(10);
    chk(to_w, 1'b0, "R2 stays stopped until reload");
  endtask

  task automatic t_one;
    val = 16'd1;
    step(1'b0, 1'b1, 1'b0);
    chk(to_w, 1'b0, "R3 V=1 before tick");
    ticks(1);
    chk(to_w, 1'b1, "R3 V=1 first tick");
    ticks(5);
    chk(to_w, 1'b1, "R6 V=1 sticky");
  endtask

  initial begin
    #500000;
    if (!done) begin
      errors++;
      $display("FAIL watchdog: actual hung expected done");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  initial begin
    @(negedge clk);
    @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    t_reset();
    t_basic();
    t_no_tick();
    t_reload();
    t_value_change();
    t_char_tick();
    t_start_char();
    t_freeze_mid();
    t_zero();
    t_one();
    done = 1'b1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule